// File: doc/BRIEF.md
# Twelve-Bit Odd Parity Unit with Shiftable Output Bit

This block computes odd parity over a 12-bit data word and presents it two ways. The direct output is combinational: it is high when an odd count of data bits is high, and an active-high mask input forces it low. A one-bit output register captures the masked parity bit, captures a serial input bit instead, or keeps its value. A hold input (active low) and a shift select input (active high) choose between these three actions.

The register has two clock inputs. A rising edge on either one updates the register while the other clock stays low. An asynchronous active-high reset clears it at once. Units can be chained by driving the serial input of each unit from the registered output of the unit before it. Under shift this forms a shift register, one stage per unit, that can carry parity results along the chain. Each output also has a complementary pin.

Top module: `parity_shift_unit`

## Requirements
- R1: With mask low, par_out is 1 exactly when the number of ones in din is odd, and 0 when it is even.
- R2: With mask high, par_out is 0 for every value of din.
- R3: While hold_n is 0, a clock edge leaves reg_out unchanged, whatever shift_sel, ser_in, mask or din hold.
- R4: With hold_n at 1 and shift_sel at 1, a clock edge loads ser_in into reg_out.
- R5: With hold_n at 1 and shift_sel at 0, a clock edge loads the current par_out value into reg_out, so a masked unit loads 0.
- R6: A high rst clears reg_out to 0 at once, with no clock edge, and takes precedence over hold and shift.
- R7: The register clock is clk_a OR clk_b. A rising edge on either input clocks the register while the other input is held low.
- R8: par_out_n is always the inverse of par_out, and reg_out_n is always the inverse of reg_out.
- R9: In a chain where each unit's reg_out drives the next unit's ser_in and every unit shifts, a bit entered at the first unit appears at the third unit's reg_out after three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Register clock, first source |
| clk_b | input | 1 | Register clock, second source |
| rst | input | 1 | Asynchronous register clear, active high |
| din | input | 12 | Data word to check |
| mask | input | 1 | Forces the direct parity output low when high |
| hold_n | input | 1 | Register keeps its value when low |
| shift_sel | input | 1 | Register loads ser_in instead of parity when high |
| ser_in | input | 1 | Serial bit for shift mode |
| par_out | output | 1 | Direct masked parity |
| par_out_n | output | 1 | Inverse of par_out |
| reg_out | output | 1 | Registered bit |
| reg_out_n | output | 1 | Inverse of reg_out |

## Verification
Hold and shift can both be active in the same cycle. The bench drives every combination of hold_n, shift_sel and mask, at random, on every unit and compares each cycle against a behavioural model in which hold wins. Reset can also meet hold and shift. The bench raises rst in the middle of a cycle with hold low and shift high and checks one nanosecond later that reg_out is 0, before any clock edge. The three-unit chain also places shifting and parity loading in adjacent units on the same edge, and the model follows each unit's old value separately.

// File: rtl/psu_pkg.sv
package psu_pkg;
  typedef enum logic [1:0] {
    NEXT_PARITY = 2'd0,
    NEXT_SERIAL = 2'd1,
    NEXT_KEEP   = 2'd2
  } next_sel_e;

  // hold (active low) outranks shift; reset is handled in the flop itself
  function automatic next_sel_e pick_next(input logic hold_n, input logic shift_sel);
    if (!hold_n)        return NEXT_KEEP;
    else if (shift_sel) return NEXT_SERIAL;
    else                return NEXT_PARITY;
  endfunction
endpackage

// File: rtl/psu_xor_tree.sv
module psu_xor_tree #(
  parameter int W = 12
) (
  input  logic [W-1:0] bits,
  output logic         odd
);
  localparam int LVLS   = (W < 2) ? 1 : $clog2(W);
  localparam int LEAVES = 1 << LVLS;

  logic node [1:2*LEAVES-1];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < W) begin : g_real
      assign node[LEAVES+j] = bits[j];
    end else begin : g_pad
      assign node[LEAVES+j] = 1'b0;
    end
  end

  for (genvar i = 1; i < LEAVES; i++) begin : g_inner
    assign node[i] = node[2*i] ^ node[2*i+1];
  end

  assign odd = node[1];
endmodule

// File: rtl/psu_clk_merge.sv
module psu_clk_merge #(
  parameter int N = 2
) (
  input  logic [N-1:0] clks,
  output logic         clk_eff
);
  assign clk_eff = |clks;
endmodule

// File: rtl/psu_out_reg.sv
module psu_out_reg
  import psu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  next_sel_e sel,
  input  logic      par_d,
  input  logic      ser_d,
  output logic      q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      case (sel)
        NEXT_SERIAL: q <= ser_d;
        NEXT_PARITY: q <= par_d;
        default:     q <= q;
      endcase
    end
  end
endmodule

// File: rtl/parity_shift_unit.sv
module parity_shift_unit
  import psu_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              mask,
  input  logic              hold_n,
  input  logic              shift_sel,
  input  logic              ser_in,
  output logic              par_out,
  output logic              par_out_n,
  output logic              reg_out,
  output logic              reg_out_n
);
  localparam int NUM_CLK = 2;

  logic      odd_raw;
  logic      clk_eff;
  next_sel_e nsel;

  psu_xor_tree #(.W(DATA_W)) u_tree (
    .bits (din),
    .odd  (odd_raw)
  );

  assign par_out   = odd_raw & ~mask;
  assign par_out_n = ~par_out;

  psu_clk_merge #(.N(NUM_CLK)) u_clk (
    .clks    ({clk_b, clk_a}),
    .clk_eff (clk_eff)
  );

  assign nsel = pick_next(hold_n, shift_sel);

  psu_out_reg u_reg (
    .clk   (clk_eff),
    .rst   (rst),
    .sel   (nsel),
    .par_d (par_out),
    .ser_d (ser_in),
    .q     (reg_out)
  );

  assign reg_out_n = ~reg_out;
endmodule

// File: rtl/psu_checker.sv
module psu_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk_eff,
  input logic              rst,
  input logic [DATA_W-1:0] din,
  input logic              mask,
  input logic              hold_n,
  input logic              shift_sel,
  input logic              ser_in,
  input logic              par_out,
  input logic              par_out_n,
  input logic              reg_out,
  input logic              reg_out_n
);
  p_odd_parity_r1: assert property (@(posedge clk_eff) disable iff (rst)
    !mask |-> (par_out == ($countones(din) % 2 == 1)));

  p_mask_low_r2: assert property (@(posedge clk_eff) disable iff (rst)
    mask |-> !par_out);

  p_hold_keeps_r3: assert property (@(posedge clk_eff) disable iff (rst)
    !hold_n |=> $stable(reg_out));

  p_shift_loads_r4: assert property (@(posedge clk_eff) disable iff (rst)
    (hold_n && shift_sel) |=> (reg_out == $past(ser_in)));

  p_parity_loads_r5: assert property (@(posedge clk_eff) disable iff (rst)
    (hold_n && !shift_sel) |=> (reg_out == $past(par_out)));

  p_reset_clears_r6: assert property (@(posedge clk_eff)
    rst |-> !reg_out);

  p_complements_r8: assert property (@(posedge clk_eff) disable iff (rst)
    (par_out_n != par_out) && (reg_out_n != reg_out));
endmodule

bind parity_shift_unit psu_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_parity_shift_unit.sv
module sim_parity_shift_unit;
  localparam int W = 12;
  localparam int NU = 3;

  logic tb_clk = 1'b0;
  logic use_b  = 1'b0;
  logic rst    = 1'b1;
  logic done   = 1'b0;
  logic clk_a, clk_b;
  logic [W-1:0] din [NU];
  logic mask [NU], hold_n [NU], shift [NU];
  logic ser0;
  logic po [NU], pon [NU], ro [NU], ron [NU];
  logic m_reg [NU];
  int nchk = 0, nfail = 0;

  always #4 tb_clk = ~tb_clk;
  assign clk_a = use_b ? 1'b0 : tb_clk;
  assign clk_b = use_b ? tb_clk : 1'b0;

  parity_shift_unit u0 (.clk_a(clk_a), .clk_b(clk_b), .rst(rst), .din(din[0]),
    .mask(mask[0]), .hold_n(hold_n[0]), .shift_sel(shift[0]), .ser_in(ser0),
    .par_out(po[0]), .par_out_n(pon[0]), .reg_out(ro[0]), .reg_out_n(ron[0]));
  parity_shift_unit u1 (.clk_a(clk_a), .clk_b(clk_b), .rst(rst), .din(din[1]),
    .mask(mask[1]), .hold_n(hold_n[1]), .shift_sel(shift[1]), .ser_in(ro[0]),
    .par_out(po[1]), .par_out_n(pon[1]), .reg_out(ro[1]), .reg_out_n(ron[1]));
  parity_shift_unit u2 (.clk_a(clk_a), .clk_b(clk_b), .rst(rst), .din(din[2]),
    .mask(mask[2]), .hold_n(hold_n[2]), .shift_sel(shift[2]), .ser_in(ro[1]),
    .par_out(po[2]), .par_out_n(pon[2]), .reg_out(ro[2]), .reg_out_n(ron[2]));

  function automatic logic exp_par(int k);
    return (($countones(din[k]) % 2) == 1) && !mask[k];
  endfunction

  // behavioural model: hold wins over shift, shift over parity load
  always @(posedge tb_clk or posedge rst) begin
    if (rst) begin
      for (int k = 0; k < NU; k++) m_reg[k] <= 1'b0;
    end else begin
      for (int k = 0; k < NU; k++) begin
        if (!hold_n[k])    m_reg[k] <= m_reg[k];
        else if (shift[k]) m_reg[k] <= (k == 0) ? ser0 : m_reg[k-1];
        else               m_reg[k] <= exp_par(k);
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge tb_clk) begin
    #2;
    if (!done) begin
      for (int k = 0; k < NU; k++) begin
        chk(mask[k] ? "R2 par_out masked" : "R1 par_out parity", po[k], exp_par(k));
        chk("R3/R4/R5/R7 reg_out vs model", ro[k], m_reg[k]);
        chk("R8 par_out_n", pon[k], ~po[k]);
        chk("R8 reg_out_n", ron[k], ~ro[k]);
      end
    end
  end

  task automatic drive_rand(bit ctl_rand);
    for (int k = 0; k < NU; k++) begin
      din[k]    = W'($urandom);
      mask[k]   = ctl_rand ? 1'($urandom) : (($urandom % 4) == 0);
      hold_n[k] = ctl_rand ? 1'($urandom) : 1'b1;
      shift[k]  = ctl_rand ? 1'($urandom) : 1'b0;
    end
    ser0 = 1'($urandom);
  endtask

  initial begin
    for (int k = 0; k < NU; k++) begin
      din[k] = '0; mask[k] = 1'b0; hold_n[k] = 1'b1; shift[k] = 1'b0;
    end
    ser0 = 1'b0;
    repeat (3) @(negedge tb_clk);
    for (int k = 0; k < NU; k++) chk("R6 reset state", ro[k], 1'b0);
    rst = 1'b0;
    // R1 R5: parity loading with occasional masking
    repeat (40) begin @(negedge tb_clk); drive_rand(1'b0); end
    // R2 R3 R4: all control combinations
    repeat (60) begin @(negedge tb_clk); drive_rand(1'b1); end
    // R7: second clock input drives the register
    @(negedge tb_clk); use_b = 1'b1;
    repeat (30) begin @(negedge tb_clk); drive_rand(1'b1); end
    @(negedge tb_clk); use_b = 1'b0;
    // R9: three-unit chain shifting a pattern
    begin
      logic hist [$];
      for (int k = 0; k < NU; k++) begin hold_n[k] = 1'b1; shift[k] = 1'b1; end
      for (int n = 0; n < 16; n++) begin
        @(negedge tb_clk);
        if (hist.size() >= 3) chk("R9 chain output", ro[2], hist[hist.size()-3]);
        ser0 = 1'(((n * 5) >> 1) & 1);
        hist.push_back(ser0);
      end
    end
    // R6: asynchronous clear mid-cycle, with hold low and shift high
    @(negedge tb_clk);
    for (int k = 0; k < NU; k++) begin hold_n[k] = 1'b1; shift[k] = 1'b0; mask[k] = 1'b0; din[k] = 12'h001; end
    @(negedge tb_clk);
    for (int k = 0; k < NU; k++) chk("R5 loaded parity 1", ro[k], 1'b1);
    for (int k = 0; k < NU; k++) begin hold_n[k] = 1'b0; shift[k] = 1'b1; end
    ser0 = 1'b1;
    #1 rst = 1'b1;
    #1;
    for (int k = 0; k < NU; k++) chk("R6 async clear", ro[k], 1'b0);
    @(negedge tb_clk);
    for (int k = 0; k < NU; k++) chk("R6 clear held", ro[k], 1'b0);
    rst = 1'b0;
    repeat (10) begin @(negedge tb_clk); drive_rand(1'b1); end
    @(negedge tb_clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule